// File: doc/BRIEF.md
# Serial Flash Status-Read Responder

This block is the target-side logic of a serial NOR flash that answers the two status-read commands. It oversamples the active-low chip select, the serial clock and a four-line data bus with the system clock. The lane mode is taken at the start of each transaction. The block gathers an 8-bit opcode and, if the opcode names the status or flag-status register, shifts that register out on the data lines that belong to the mode.

It repeats the register byte for as long as the host keeps clocking with select held low. It takes a fresh copy of the register at every byte boundary, so a busy bit that clears mid-stream shows up in the following byte. The register values are plain inputs, and they stay readable whatever the surrounding program or erase logic is doing. Raising select aborts the transaction at any point and releases every line.

Top module: `flash_status_resp`

## Requirements
- R1: After reset, every output enable is 0 and every data output is 0.
- R2: While select is high, serial clocks and data are ignored and all lines stay released. A transaction starts only with select low, and always from opcode bit 0.
- R3: Mode code 00 (extended) takes one opcode bit per rising edge from lane 0, most significant bit first. Data leaves on lane 1 only, with output enable 4'b0010.
- R4: Mode code 01 (dual) moves two bits per clock on lanes 1:0 in both directions, with lane 1 carrying the higher-order bit. Output enable is 4'b0011.
- R5: Mode codes 10 and 11 (quad) move four bits per clock on lanes 3:0, with lane 3 carrying the highest-order bit. Output enable is 4'b1111.
- R6: Opcode 0x05 returns the status value and opcode 0x70 returns the flag-status value.
- R7: Any other opcode leaves every line released for the rest of the transaction, however many clocks follow.
- R8: Output groups change only after a falling serial-clock edge and hold through the following rising edge. The first group is the most significant one and appears after the first falling edge that follows the last opcode bit.
- R9: The selected byte is sent again and again with no new opcode while clocks continue.
- R10: The register is captured at the start of each byte. A change made mid-byte does not disturb that byte and appears in the next byte.
- R11: Raising select releases all lines within SYNC_STAGES+1 system clocks, discards any partial opcode, and leaves the next transaction unaffected.
- R12: The mode is latched when select falls. A change of the mode input during a transaction has no effect until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| dq_in | input | 4 | Data lanes as seen by the target |
| mode_sel | input | 2 | Lane mode: 00 extended, 01 dual, 1x quad |
| status_val | input | 8 | Current status register contents |
| flag_val | input | 8 | Current flag-status register contents |
| dq_out | output | 4 | Driven lane values |
| dq_oe | output | 4 | Per-lane output enable |

## Verification
The bench sweeps every lane mode against both opcodes and a spread of register values. It puts the complement in the other register, so a design that returns the wrong register or drops a lane mapping gives wrong groups. It sends invalid opcodes, clocks with select high, and aborts one transaction mid-opcode and one mid-data. A design that kept its bit counter across a deselect would then decode a mixed opcode, and one that kept driving would leave output enables set. A mid-byte register change and a mid-transaction mode change catch designs that capture the register per bit instead of per byte, or that follow the live mode input.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    LM_SINGLE = 2'd0,
    LM_DUAL   = 2'd1,
    LM_QUAD   = 2'd2
  } lane_mode_e;

  function automatic lane_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd0:    return LM_SINGLE;
      2'd1:    return LM_DUAL;
      default: return LM_QUAD;
    endcase
  endfunction

  function automatic logic [3:0] lane_count(input lane_mode_e m);
    case (m)
      LM_SINGLE: return 4'd1;
      LM_DUAL:   return 4'd2;
      default:   return 4'd4;
    endcase
  endfunction

  function automatic logic [LANES-1:0] oe_mask(input lane_mode_e m);
    case (m)
      LM_SINGLE: return 4'b0010;
      LM_DUAL:   return 4'b0011;
      default:   return 4'b1111;
    endcase
  endfunction

  // right-aligned input bits taken on one rising edge
  function automatic logic [3:0] gather(input lane_mode_e m, input logic [LANES-1:0] dq);
    case (m)
      LM_SINGLE: return {3'b000, dq[0]};
      LM_DUAL:   return {2'b00, dq[1:0]};
      default:   return dq;
    endcase
  endfunction

  // place the top nibble of the outgoing byte on the lanes
  function automatic logic [LANES-1:0] scatter(input lane_mode_e m, input logic [3:0] top);
    case (m)
      LM_SINGLE: return {2'b00, top[3], 1'b0};
      LM_DUAL:   return {2'b00, top[3:2]};
      default:   return top;
    endcase
  endfunction
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RESET_VAL;
        else     pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RESET_VAL;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fsr_cmd_rx.sv
module fsr_cmd_rx
  import fsr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OP_STATUS = 8'h05,
  parameter logic [BYTE_W-1:0] OP_FLAG   = 8'h70
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             rise,
  input  lane_mode_e       mode,
  input  logic [LANES-1:0] lanes_in,
  output logic             start,
  output logic             use_flag
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;

  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [BYTE_W-1:0] op, op_nxt;
  logic              done;
  logic [3:0]        w;

  always_comb begin
    w       = lane_count(mode);
    op_nxt  = (op << w) | BYTE_W'(gather(mode, lanes_in));
    cnt_nxt = cnt + CNT_W'(w);
  end

  always_ff @(posedge clk) begin
    if (rst || sel_n) begin
      cnt      <= '0;
      op       <= '0;
      done     <= 1'b0;
      start    <= 1'b0;
      use_flag <= 1'b0;
    end else begin
      start <= 1'b0;
      if (rise && !done) begin
        op  <= op_nxt;
        cnt <= cnt_nxt;
        if (cnt_nxt == CNT_W'(BYTE_W)) begin
          done <= 1'b1;
          if (op_nxt == OP_STATUS) begin
            start    <= 1'b1;
            use_flag <= 1'b0;
          end else if (op_nxt == OP_FLAG) begin
            start    <= 1'b1;
            use_flag <= 1'b1;
          end
        end
      end
    end
  end

  // R2: a deselected bus never launches a read
  p_no_start_deselected_r2: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> !start);
  // R6: a decode always follows a sampled rising edge
  p_start_after_rise_r6: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(rise));
endmodule

// File: rtl/fsr_data_tx.sv
module fsr_data_tx
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              start,
  input  logic              use_flag,
  input  logic              fall,
  input  lane_mode_e        mode,
  input  logic [BYTE_W-1:0] stat_val,
  input  logic [BYTE_W-1:0] flag_val,
  output logic [LANES-1:0]  dq_out,
  output logic [LANES-1:0]  dq_oe
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;

  logic              active;
  logic [BYTE_W-1:0] sh, src;
  logic [CNT_W-1:0]  left;
  logic [3:0]        w;

  always_comb begin
    w   = lane_count(mode);
    src = (left == '0) ? (use_flag ? flag_val : stat_val) : sh;
  end

  always_ff @(posedge clk) begin
    if (rst || sel_n) begin
      active <= 1'b0;
      sh     <= '0;
      left   <= '0;
      dq_out <= '0;
      dq_oe  <= '0;
    end else if (start) begin
      active <= 1'b1;
      left   <= '0;
    end else if (fall && active) begin
      dq_out <= scatter(mode, src[BYTE_W-1 -: 4]);
      dq_oe  <= oe_mask(mode);
      sh     <= src << w;
      left   <= (left == '0) ? CNT_W'(BYTE_W) - CNT_W'(w) : left - CNT_W'(w);
    end
  end

  // R8: lanes only move on a falling serial edge
  p_hold_between_falls_r8: assert property (@(posedge clk) disable iff (rst)
    (!fall && !sel_n) |=> $stable(dq_out));
  // R8: drive begins right after a falling edge
  p_drive_after_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(|dq_oe) |-> $past(fall));
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import fsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] OP_STATUS = 8'h05,
  parameter logic [7:0] OP_FLAG   = 8'h70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] dq_in,
  input  logic [1:0] mode_sel,
  input  logic [7:0] status_val,
  input  logic [7:0] flag_val,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe
);
  localparam int PIN_W = 2 + LANES;

  logic [PIN_W-1:0] pins_s;
  logic             s_cs, s_sck, cs_q, sck_q;
  logic [LANES-1:0] s_dq;
  logic             rise, fall, start, use_flag;
  lane_mode_e       mode_l;

  fsr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES),
             .RESET_VAL({1'b1, 1'b0, {LANES{1'b0}}})) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, dq_in}), .q(pins_s));

  assign {s_cs, s_sck, s_dq} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      mode_l <= LM_SINGLE;
    end else begin
      cs_q  <= s_cs;
      sck_q <= s_sck;
      if (cs_q && !s_cs) mode_l <= decode_mode(mode_sel);
    end
  end

  assign rise = s_sck && !sck_q;
  assign fall = !s_sck && sck_q;

  fsr_cmd_rx #(.OP_STATUS(OP_STATUS), .OP_FLAG(OP_FLAG)) u_cmd (
    .clk(clk), .rst(rst), .sel_n(s_cs), .rise(rise), .mode(mode_l),
    .lanes_in(s_dq), .start(start), .use_flag(use_flag));

  fsr_data_tx u_tx (
    .clk(clk), .rst(rst), .sel_n(s_cs), .start(start), .use_flag(use_flag),
    .fall(fall), .mode(mode_l), .stat_val(status_val), .flag_val(flag_val),
    .dq_out(dq_out), .dq_oe(dq_oe));

  // R11: a deselected bus leaves all lanes released
  p_release_on_deselect_r11: assert property (@(posedge clk) disable iff (rst)
    s_cs |=> (dq_oe == '0));
  // R12: the latched mode moves only while select is high or falling
  p_mode_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    (!s_cs && !cs_q) |=> $stable(mode_l));
endmodule

// File: tb/flash_status_resp_tb.sv
module flash_status_resp_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] dq_in = 4'h0;
  logic [1:0] mode_sel = 2'd0;
  logic [7:0] status_val = 8'h00;
  logic [7:0] flag_val = 8'h00;
  logic [3:0] dq_out, dq_oe;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_status_resp u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
    .mode_sel(mode_sel), .status_val(status_val), .flag_val(flag_val),
    .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int wid(input int m);
    return (m == 0) ? 1 : ((m == 1) ? 2 : 4);
  endfunction

  function automatic logic [3:0] mask(input int m);
    return (m == 0) ? 4'b0010 : ((m == 1) ? 4'b0011 : 4'b1111);
  endfunction

  function automatic logic [3:0] grp_dq(input int m, input logic [7:0] b, input int k);
    int w = wid(m);
    int g = (int'(b) >> (8 - w * (k + 1))) & ((1 << w) - 1);
    return (m == 0) ? 4'(g << 1) : 4'(g);
  endfunction

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic send_bits(input int m, input logic [7:0] op, input int ngroups);
    int w = wid(m);
    for (int g = 0; g < ngroups; g++) begin
      int gv = (int'(op) >> (8 - w * (g + 1))) & ((1 << w) - 1);
      sck = 1'b0;
      if (m == 0) dq_in = {3'b111, gv[0]};
      else if (m == 1) dq_in = {2'b10, gv[1:0]};
      else dq_in = 4'(gv);
      half();
      sck = 1'b1;
      half();
    end
  endtask

  task automatic read_groups(input int m, input logic [7:0] b, input int k0,
                             input int k1, input string req);
    for (int k = k0; k < k1; k++) begin
      sck = 1'b0;
      half();
      chk(req, {dq_oe, dq_out & mask(m)}, {mask(m), grp_dq(m, b, k)});
      sck = 1'b1;
      half();
      chk("R8 hold over rising edge", {dq_oe, dq_out & mask(m)}, {mask(m), grp_dq(m, b, k)});
    end
  endtask

  task automatic read_byte(input int m, input logic [7:0] b, input string req);
    read_groups(m, b, 0, 8 / wid(m), req);
  endtask

  task automatic begin_txn(input int m);
    mode_sel = 2'(m);
    half();
    cs_n = 1'b0;
    half();
  endtask

  task automatic end_txn();
    sck = 1'b0;
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 release on deselect", {4'h0, dq_oe}, 8'h00);
    half();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", {dq_oe, dq_out}, 8'h00);

    // main sweep over modes, registers and values (R3 R4 R5 R6 R9)
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int vi = 0; vi < 6; vi++) begin
          logic [7:0] v;
          string tag;
          v = (vi == 0) ? 8'h00 : ((vi == 1) ? 8'hFF : 8'((vi * 53 + m * 29 + s * 7 + 1) & 255));
          status_val = s ? ~v : v;
          flag_val   = s ? v : ~v;
          tag = (m == 0) ? "R3 extended R6 select" : ((m == 1) ? "R4 dual R6 select" : "R5 quad R6 select");
          begin_txn(m);
          send_bits(m, s ? 8'h70 : 8'h05, 8 / wid(m));
          read_byte(m, v, tag);
          read_byte(m, v, "R9 repeated byte");
          end_txn();
        end
      end
    end

    // mode code 11 behaves as quad (R5)
    status_val = 8'hA7;
    begin_txn(3);
    send_bits(2, 8'h05, 2);
    read_byte(2, 8'hA7, "R5 code 11 quad");
    end_txn();

    // invalid opcodes (R7)
    for (int m = 0; m < 3; m++) begin
      for (int oi = 0; oi < 5; oi++) begin
        logic [7:0] op;
        op = (oi == 0) ? 8'h06 : (oi == 1) ? 8'h71 : (oi == 2) ? 8'h00 : (oi == 3) ? 8'hFF : 8'h85;
        begin_txn(m);
        send_bits(m, op, 8 / wid(m));
        for (int k = 0; k < 8; k++) begin
          sck = 1'b0;
          half();
          chk("R7 invalid opcode stays released", {4'h0, dq_oe}, 8'h00);
          sck = 1'b1;
          half();
        end
        end_txn();
      end
    end

    // clocks while deselected are ignored (R2)
    status_val = 8'h5A;
    flag_val   = 8'hC3;
    mode_sel   = 2'd0;
    send_bits(0, 8'h05, 8);
    for (int k = 0; k < 4; k++) begin
      sck = 1'b0;
      half();
      chk("R2 deselected clocks ignored", {4'h0, dq_oe}, 8'h00);
      sck = 1'b1;
      half();
    end
    sck = 1'b0;
    half();
    begin_txn(0);
    send_bits(0, 8'h05, 8);
    read_byte(0, 8'h5A, "R2 fresh start after deselect");
    end_txn();

    // partial opcode discarded by deselect (R11)
    begin_txn(2);
    send_bits(2, 8'h70, 1);
    end_txn();
    begin_txn(2);
    send_bits(2, 8'h05, 2);
    read_byte(2, 8'h5A, "R11 restart after aborted opcode");
    end_txn();

    // abort during data output (R11)
    begin_txn(1);
    send_bits(1, 8'h70, 4);
    read_groups(1, 8'hC3, 0, 2, "R4 dual before abort");
    sck = 1'b0;
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 abort mid-data", {4'h0, dq_oe}, 8'h00);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1;
      half();
      sck = 1'b0;
      half();
      chk("R11 no drive after abort", {4'h0, dq_oe}, 8'h00);
    end

    // register captured per byte (R10)
    status_val = 8'h81;
    begin_txn(0);
    send_bits(0, 8'h05, 8);
    read_groups(0, 8'h81, 0, 3, "R10 first byte head");
    status_val = 8'h3C;
    read_groups(0, 8'h81, 3, 8, "R10 first byte unchanged");
    read_byte(0, 8'h3C, "R10 next byte updated");
    end_txn();

    // mode latched at select fall (R12)
    flag_val = 8'h96;
    begin_txn(1);
    send_bits(1, 8'h70, 4);
    mode_sel = 2'd2;
    read_byte(1, 8'h96, "R12 mode held");
    end_txn();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule